// File: doc/BRIEF.md
# Even-Ratio Clock Divider

This block divides its input clock by an even ratio between 2 and 16, chosen by a 3-bit select. The result is a square wave with equal high and low times, held in a flop clocked by the input clock, so it carries no combinational glitches. The output starts on a clean rising edge when the divider is enabled and stops only once the current output period has fully completed. No truncated pulse ever reaches the clock consumers.

Two inputs control it. An active-low synchronous reset puts the block in a known idle state. An active-high synchronous stop request, `div_clr`, turns the output off at the next period boundary and keeps it off for as long as it stays high. An elaboration-time parameter selects a start-up delay. With the delay on, every start waits one whole output period (N input cycles) before the first rising edge.

Top module: `evenclk_div`

## Requirements
- R1: The select value S on `ratio_sel` (0 to 7) gives a division ratio N = 2*(S+1). So 3'b000 divides by 2 and 3'b111 divides by 16, and every output period is N input cycles long.
- R2: While running, each high phase and each low phase lasts H = S+1 input cycles, which gives a 50% duty cycle at every ratio.
- R3: When `rst_n` is low at a rising clock edge, `clk_out` is 0 after that edge and the block is idle, whatever `div_clr` is.
- R4: When `div_clr` is seen high while the output runs, the current high phase still completes with its full H cycles. The output goes idle at the edge that would have started the next high phase, so no low phase is shorter than H.
- R5: With the delay off, when the block is idle and `div_clr` is low at a rising edge, `clk_out` is 1 right after that same edge.
- R6: With `DELAY_EN` = 1, the first rising edge of `clk_out` after a start comes 2H input cycles after the start edge, and that first high phase lasts H cycles.
- R7: `ratio_sel` is captured only at a start edge or at the edge that begins a new period. A change in the middle of a period leaves the rest of that period unchanged, and the following period uses the new ratio.
- R8: While idle, `clk_out` is held at 0. Keeping `div_clr` high keeps it there.
- R9: A `div_clr` seen during the start-up delay returns the block to idle at that edge. With `div_clr` high for one cycle, two cycles after a start, the first rising edge comes 2H+1 sampled cycles after the clear was released.
- R10: A stop request that lasts a single cycle is remembered until the period boundary. The output then rests for one cycle and restarts, so that low phase is H+1 cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| div_clr | input | 1 | Synchronous stop request, active high |
| ratio_sel | input | 3 | Ratio select, N = 2*(value+1) |
| clk_out | output | 1 | Divided clock, registered |

## Verification
Every result appears one edge after the input that causes it. A start shows as `clk_out` high in the half-cycle after the start edge. A stop shows as a low phase that is extended rather than cut short. A delayed start shows as exactly 2H low samples before the first high. The bench drives inputs 2 ns after a rising edge and samples outputs on the falling edge. It counts high and low samples between transitions and compares them with H taken from the select value present at the edge that raised the output, so each count matches the edge where the design acted. For the latency checks the bench first waits for the start edge itself and only then counts, so the sample that precedes the start edge is never mistaken for a result.

// File: rtl/evenclk_pkg.sv
// Package: shared types for the even-ratio clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package evenclk_pkg;

    // Operating phase of the divider.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

endpackage

// File: rtl/evenclk_cnt.sv
// Module: half-period counter. It counts up from zero and raises tc when
// the count equals the target it is given. On tc it reloads to zero.
// Assumes: target is stable within one count, and clr has priority.
module evenclk_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tc
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Terminal-count detect.
    assign tc = (cnt_q == target);

    // Count register with clear and reload.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/evenclk_wave.sv
// Module: output wave register. It is set or cleared on command and
// otherwise holds its value.
// Assumes: clr has priority over set; reset drives the wave low.
module evenclk_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic wave_q
);

    // Registered output, so the divided clock never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wave_q <= 1'b0;
        end else if (set) begin
            wave_q <= 1'b1;
        end
    end

endmodule

// File: rtl/evenclk_ctrl.sv
// Module: control for the divider. It tracks idle, delay and run phases,
// captures the ratio at start and period boundaries, holds a stop request
// until the boundary, and tells the counter and the wave register what
// to do.
// Assumes: tc comes from a counter cleared whenever the phase is idle.
module evenclk_ctrl
    import evenclk_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int CNT_W    = SEL_W + 2,
    parameter bit DELAY_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_clr,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             tc,
    input  logic             wave_q,
    output phase_e           phase_q,
    output logic [CNT_W-1:0] half_q,
    output logic [CNT_W-1:0] target,
    output logic             cnt_clr,
    output logic             wave_set,
    output logic             wave_clr
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           phase_d;
    logic [CNT_W-1:0] half_d;
    logic             pend_q;
    logic             pend_d;

    // Counter target: a full period while delaying, a half period while running.
    assign target  = (phase_q == PH_DELAY) ? ((half_q << 1) - ONE) : (half_q - ONE);
    // The counter rests at zero while idle.
    assign cnt_clr = (phase_q == PH_IDLE);

    // Next-state decode for phase, ratio, pending stop and wave commands.
    always_comb begin
        phase_d  = phase_q;
        half_d   = half_q;
        pend_d   = pend_q;
        wave_set = 1'b0;
        wave_clr = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                pend_d = 1'b0;
                if (!div_clr) begin
                    half_d = CNT_W'(ratio_sel) + ONE;
                    if (DELAY_EN) begin
                        phase_d = PH_DELAY;
                    end else begin
                        phase_d  = PH_RUN;
                        wave_set = 1'b1;
                    end
                end
            end
            PH_DELAY: begin
                if (div_clr) begin
                    phase_d = PH_IDLE;
                end else if (tc) begin
                    phase_d  = PH_RUN;
                    wave_set = 1'b1;
                end
            end
            PH_RUN: begin
                pend_d = pend_q | div_clr;
                if (tc && wave_q) begin
                    wave_clr = 1'b1;
                end else if (tc) begin
                    if (div_clr || pend_q) begin
                        phase_d  = PH_IDLE;
                        pend_d   = 1'b0;
                        wave_clr = 1'b1;
                    end else begin
                        half_d   = CNT_W'(ratio_sel) + ONE;
                        wave_set = 1'b1;
                    end
                end
            end
            default: begin
                phase_d  = PH_IDLE;
                wave_clr = 1'b1;
            end
        endcase
    end

    // Control state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            half_q  <= ONE;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            half_q  <= half_d;
            pend_q  <= pend_d;
        end
    end

endmodule

// File: rtl/evenclk_div.sv
// Module: even-ratio clock divider top. It divides clk_in by 2*(ratio_sel+1)
// and gives a 50% duty output that starts and stops only on whole periods.
// Assumes: all inputs are synchronous to clk_in.
module evenclk_div
    import evenclk_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter bit DELAY_EN = 1'b0
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             div_clr,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             clk_out
);

    localparam int CNT_W = SEL_W + 2;

    phase_e           phase_q;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_q;
    logic             tc;
    logic             cnt_clr;
    logic             wave_set;
    logic             wave_clr;

    evenclk_ctrl #(
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W),
        .DELAY_EN (DELAY_EN)
    ) u_ctrl (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .div_clr   (div_clr),
        .ratio_sel (ratio_sel),
        .tc        (tc),
        .wave_q    (clk_out),
        .phase_q   (phase_q),
        .half_q    (half_q),
        .target    (target),
        .cnt_clr   (cnt_clr),
        .wave_set  (wave_set),
        .wave_clr  (wave_clr)
    );

    evenclk_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .target (target),
        .cnt_q  (cnt_q),
        .tc     (tc)
    );

    evenclk_wave u_wave (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .set    (wave_set),
        .clr    (wave_clr),
        .wave_q (clk_out)
    );

endmodule

// File: rtl/evenclk_div_chk.sv
// Module: property checker for the divider, attached to the top by bind.
// Assumes: signals are sampled on the rising edge of clk_in.
module evenclk_div_chk
    import evenclk_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter bit DELAY_EN = 1'b0
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             div_clr,
    input logic             clk_out,
    input phase_e           phase_q,
    input logic [CNT_W-1:0] half_q,
    input logic [CNT_W-1:0] cnt_q
);

    logic [CNT_W-1:0] hi_len;

    // Counts consecutive high cycles of the output.
    always_ff @(posedge clk_in) begin
        if (!rst_n || !clk_out) begin
            hi_len <= '0;
        end else begin
            hi_len <= hi_len + CNT_W'(1);
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> !clk_out); // R8

    AST_DELAY_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_q == PH_DELAY) |-> !clk_out); // R6

    AST_STOP_AT_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        ((phase_q == PH_IDLE) && ($past(phase_q) == PH_RUN) && $past(rst_n)) |-> !$past(clk_out)); // R4

    AST_START_EDGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        ((phase_q == PH_IDLE) && !div_clr) |=> (clk_out == !DELAY_EN)); // R5

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk_in) disable iff (!rst_n)
        (($past(phase_q) == PH_RUN) && (half_q != $past(half_q)) && $past(rst_n)) |-> $rose(clk_out)); // R7

    AST_CNT_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        cnt_q < (half_q << 1)); // R1

    AST_HIGH_WIDTH: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($fell(clk_out) && $past(rst_n)) |-> (hi_len == half_q)); // R2

endmodule

bind evenclk_div evenclk_div_chk #(
    .CNT_W    (CNT_W),
    .DELAY_EN (DELAY_EN)
) u_chk (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .div_clr (div_clr),
    .clk_out (clk_out),
    .phase_q (phase_q),
    .half_q  (half_q),
    .cnt_q   (cnt_q)
);

// File: tb/evenclk_div_bench.sv
// Bench: directed corner cases plus seeded random stop and ratio traffic.
// The undelayed instance is checked by a period monitor. The delayed
// instance gets directed latency checks.
module evenclk_div_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_clr = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       out_n;
    logic       out_d;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evenclk_div #(.SEL_W(3), .DELAY_EN(1'b0)) u_evenclk_div (
        .clk_in (clk), .rst_n (rst_n), .div_clr (div_clr),
        .ratio_sel (ratio_sel), .clk_out (out_n)
    );

    evenclk_div #(.SEL_W(3), .DELAY_EN(1'b1)) u_evenclk_div_dly (
        .clk_in (clk), .rst_n (rst_n), .div_clr (div_clr),
        .ratio_sel (ratio_sel), .clk_out (out_d)
    );

    function automatic int half_of(input logic [2:0] s);
        return int'(s) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drv();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) drv();
    endtask

    // Period monitor on the undelayed output.
    bit         mon_en = 1'b0;
    int         mon_prev = 0;
    int         hi_run = 0;
    int         lo_run = 0;
    int         hi_last = 0;
    int         h_cur = 1;
    bit         first = 1'b1;
    bit         stop_seen = 1'b0;
    logic [2:0] sel_prev = 3'd0;

    always @(negedge clk) begin
        if (!mon_en) begin
            first = 1'b1; hi_run = 0; lo_run = 0; stop_seen = 1'b0;
            mon_prev = int'(out_n);
        end else begin
            if (out_n && mon_prev == 0) begin
                if (!first) begin
                    if (stop_seen) begin
                        check(lo_run >= h_cur, "R4 low phase not shortened", lo_run, h_cur);
                    end else begin
                        check(lo_run == h_cur, "R2 low phase", lo_run, h_cur);
                        check(hi_last + lo_run == 2 * h_cur, "R1 period", hi_last + lo_run, 2 * h_cur);
                    end
                end
                first = 1'b0;
                h_cur = half_of(sel_prev);
                hi_run = 1; lo_run = 0; stop_seen = 1'b0;
            end else if (out_n) begin
                hi_run++;
            end else if (mon_prev == 1) begin
                check(hi_run == h_cur, "R2 high phase", hi_run, h_cur);
                hi_last = hi_run;
                lo_run = 1;
            end else begin
                lo_run++;
            end
            if (div_clr) stop_seen = 1'b1;
            mon_prev = int'(out_n);
        end
        sel_prev = ratio_sel;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int m;
        void'($urandom(32'h00C0FFEE));

        // R3: reset holds outputs low even with the stop request released.
        wait_cyc(4);
        @(negedge clk);
        check(out_n == 1'b0, "R3 reset low", int'(out_n), 0);
        check(out_d == 1'b0, "R3 reset low (delay)", int'(out_d), 0);
        drv();
        div_clr = 1'b1;
        rst_n = 1'b1;
        wait_cyc(2);
        mon_en = 1'b1;

        // Per-ratio sweep: start latency, delay latency, widths, clean stop.
        for (int s = 0; s < 8; s++) begin
            drv();
            div_clr = 1'b1;
            ratio_sel = 3'(s);
            wait_cyc(36);
            @(negedge clk);
            check(out_n == 1'b0, "R8 idle low", int'(out_n), 0);
            check(out_d == 1'b0, "R8 idle low (delay)", int'(out_d), 0);
            drv();
            div_clr = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(out_n == 1'b1, "R5 start edge", int'(out_n), 1);
            n = 0;
            while (out_d == 1'b0 && n < 100) begin n++; @(negedge clk); end
            check(n == 2 * half_of(3'(s)), "R6 delayed first rise", n, 2 * half_of(3'(s)));
            m = 0;
            while (out_d == 1'b1 && m < 100) begin m++; @(negedge clk); end
            check(m == half_of(3'(s)), "R6 first high width", m, half_of(3'(s)));
            wait_cyc(4 * half_of(3'(s)) + 1);
        end

        // R9: clear during the start-up delay returns to idle at once.
        drv();
        div_clr = 1'b1;
        ratio_sel = 3'd2;
        wait_cyc(40);
        div_clr = 1'b0;
        drv();
        drv();
        div_clr = 1'b1;
        drv();
        div_clr = 1'b0;
        @(negedge clk);
        n = 0;
        while (out_d == 1'b0 && n < 100) begin n++; @(negedge clk); end
        check(n == 2 * 3 + 1, "R9 delay abort", n, 7);
        wait_cyc(20);

        // R10: one-cycle stop request in a high phase.
        drv();
        ratio_sel = 3'd3;
        wait_cyc(20);
        @(negedge clk);
        while (!(out_n == 1'b1)) @(negedge clk);
        while (out_n == 1'b1) @(negedge clk);
        while (out_n == 1'b0) @(negedge clk);
        drv();
        div_clr = 1'b1;
        drv();
        div_clr = 1'b0;
        @(negedge clk);
        while (out_n == 1'b1) @(negedge clk);
        n = 0;
        while (out_n == 1'b0 && n < 100) begin n++; @(negedge clk); end
        check(n == 5, "R10 single-cycle stop", n, 5);

        // R7: ratio change in mid high phase takes effect next period.
        while (out_n == 1'b1) @(negedge clk);
        while (out_n == 1'b0) @(negedge clk);
        drv();
        ratio_sel = 3'd0;
        @(negedge clk);
        m = 1;
        while (out_n == 1'b1 && m < 100) begin m++; @(negedge clk); end
        check(m == 4, "R7 current high keeps old ratio", m, 4);
        n = 0;
        while (out_n == 1'b0 && n < 100) begin n++; @(negedge clk); end
        check(n == 4, "R7 current low keeps old ratio", n, 4);
        m = 0;
        while (out_n == 1'b1 && m < 100) begin m++; @(negedge clk); end
        check(m == 1, "R7 next high uses new ratio", m, 1);

        // R3: reset in mid run forces the output low after the edge.
        drv();
        ratio_sel = 3'd5;
        wait_cyc(30);
        @(negedge clk);
        while (out_n == 1'b0) @(negedge clk);
        mon_en = 1'b0;
        drv();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_n == 1'b0, "R3 reset mid run", int'(out_n), 0);
        check(out_d == 1'b0, "R3 reset mid run (delay)", int'(out_d), 0);
        wait_cyc(3);
        div_clr = 1'b1;
        rst_n = 1'b1;
        wait_cyc(2);
        mon_en = 1'b1;
        div_clr = 1'b0;

        // Seeded random ratio changes and stop requests, checked by the monitor.
        for (int it = 0; it < 150; it++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: begin
                    ratio_sel = 3'($urandom % 8);
                    wait_cyc(1 + int'($urandom % 20));
                end
                1: begin
                    div_clr = 1'b1;
                    drv();
                    div_clr = 1'b0;
                    wait_cyc(1 + int'($urandom % 10));
                end
                2: begin
                    div_clr = 1'b1;
                    wait_cyc(1 + int'($urandom % 30));
                    div_clr = 1'b0;
                    wait_cyc(1 + int'($urandom % 5));
                end
                default: wait_cyc(1 + int'($urandom % 40));
            endcase
        end

        // R8: a held stop request leaves the output low.
        div_clr = 1'b1;
        wait_cyc(40);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(out_n == 1'b0, "R8 held stop keeps low", int'(out_n), 0);
            drv();
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule